// File: doc/BRIEF.md
# Twos Complement Adder-Subtractor with Status Flags

This block adds or subtracts two 8-bit operands held in twos complement form. Both operations share one ripple-carry adder. In subtract mode the second operand is inverted bit by bit and the adder's carry-in is forced to 1, so the adder forms A + ~B + 1, which equals A − B.

The block captures an operation on the clock edge where the strobe is high. On that edge it registers the result and an 8-bit status word. The status word holds carry, zero, negative and signed overflow. In subtract mode the carry bit reads as "no borrow", so it is set when A ≥ B as unsigned numbers. One cycle later the block raises a single-cycle valid pulse.

An upstream sequencer uses the block by presenting operands and a mode, then reading the result and flags when the pulse appears.

Top module: `addsub_flags_unit`

## Requirements
- R1: While the synchronous active-low reset is sampled low at a clock edge, the result register, the whole status word and the valid pulse are cleared to 0.
- R2: With the mode input at 0 (add), an edge with the strobe high loads the result with (A + B) mod 256.
- R3: With the mode input at 1 (subtract), an edge with the strobe high loads the result with (A − B) mod 256, formed as A + ~B + 1.
- R4: Status bit 0 (carry) takes the carry out of bit 7. In add mode it is 1 when the unsigned sum exceeds 255. In subtract mode it is 1 exactly when A ≥ B as unsigned numbers.
- R5: Status bit 1 (zero) is 1 exactly when the captured result is 00000000. For example, adding a value to its twos complement sets it.
- R6: Status bit 2 (negative) equals bit 7 of the captured result.
- R7: Status bit 3 (overflow) is the XOR of the carry into bit 7 and the carry out of bit 7. It is set when:
  - in add mode, two operands of the same sign give a result of the other sign (115 + 91 gives 11001110 with the flag set);
  - in subtract mode, operands of different sign give a result whose sign differs from A.
- R8: Status bits 7 to 4 always read 0.
- R9: The valid output is high for exactly the one cycle after an edge where the strobe was high. While the strobe is low, the result and status hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Strobe: capture an operation on this edge |
| op_sub | input | 1 | Mode: 0 = add, 1 = subtract |
| opa | input | 8 | Operand A (minuend in subtract mode) |
| opb | input | 8 | Operand B (subtrahend in subtract mode) |
| sum_out | output | 8 | Registered result |
| flags_out | output | 8 | Registered status word: bit 0 carry, bit 1 zero, bit 2 negative, bit 3 overflow, bits 7..4 zero |
| res_valid | output | 1 | One-cycle pulse marking a fresh result |

## Verification
The result, the status word and the valid pulse are all due one register stage after the accepting edge. The bench therefore drives operands on a falling edge and lets one rising edge capture them. It then compares all three outputs on the next falling edge, half a period after that capture. A hold check drops the strobe for one further edge and samples again on the following falling edge, where the pulse must be low and the result and status must be unchanged.

// File: rtl/addsub_pkg.sv
// Package: shared widths and status word bit positions for the adder-subtractor.
// Assumes a status word of at least four bits; the upper bits are reserved zero.
package addsub_pkg;
    localparam int DATA_W = 8;
    localparam int STAT_W = 8;
    localparam int FLAG_CARRY = 0;
    localparam int FLAG_ZERO  = 1;
    localparam int FLAG_NEG   = 2;
    localparam int FLAG_OVF   = 3;
    localparam int FLAG_USED  = 4;
endpackage

// File: rtl/operand_prep.sv
// Module: operand_prep
// Conditions the second operand for the shared adder. In subtract mode every
// bit is inverted and the carry-in is forced high. Purely combinational.
module operand_prep #(
    parameter int W = 8
) (
    input  logic [W-1:0] b_in,
    input  logic         sub,
    output logic [W-1:0] b_eff,
    output logic         cin
);
    // One conditional inverter per operand bit.
    for (genvar i = 0; i < W; i++) begin : g_inv
        assign b_eff[i] = b_in[i] ^ sub;
    end

    // Subtract adds the +1 of the twos complement through the carry-in.
    assign cin = sub;
endmodule

// File: rtl/ripple_adder.sv
// Module: ripple_adder
// W-bit ripple-carry adder built from full-adder cells. Besides the carry out
// of the top bit it exposes the carry into the top bit, for overflow detection.
// Assumes W >= 2.
module ripple_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_into_msb,
    output logic         c_out
);
    logic [W:0] chain;

    assign chain[0] = cin;

    // Full-adder cell per bit, carries rippling upward.
    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum[i]     = a[i] ^ b[i] ^ chain[i];
        assign chain[i+1] = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
    end

    assign c_into_msb = chain[W-1];
    assign c_out      = chain[W];
endmodule

// File: rtl/flag_gen.sv
// Module: flag_gen
// Builds the status word from an adder result and its top carries.
// Bit positions come from addsub_pkg; reserved bits are driven to 0.
module flag_gen
    import addsub_pkg::*;
#(
    parameter int W  = 8,
    parameter int FW = 8
) (
    input  logic [W-1:0]  sum,
    input  logic          c_into_msb,
    input  logic          c_out,
    output logic [FW-1:0] flags
);
    // Arithmetic flag bits.
    assign flags[FLAG_CARRY] = c_out;
    assign flags[FLAG_ZERO]  = ~|sum;
    assign flags[FLAG_NEG]   = sum[W-1];
    assign flags[FLAG_OVF]   = c_into_msb ^ c_out;

    // Reserved upper bits are tied low.
    for (genvar k = FLAG_USED; k < FW; k++) begin : g_rsv
        assign flags[k] = 1'b0;
    end
endmodule

// File: rtl/addsub_flags_unit.sv
// Module: addsub_flags_unit
// Twos complement adder-subtractor with a registered status word.
// An operation is captured on a rising edge with op_valid high. The result and
// status register then, and res_valid pulses for one cycle after that edge.
// Reset is synchronous and active low. Assumes DATA_W >= 2 and STAT_W >= 4.
module addsub_flags_unit
    import addsub_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int FW = STAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic          op_sub,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    output logic [W-1:0]  sum_out,
    output logic [FW-1:0] flags_out,
    output logic          res_valid
);
    localparam int MSB = W - 1;

    logic [W-1:0]  b_eff;
    logic          cin;
    logic [W-1:0]  raw_sum;
    logic          c_msb;
    logic          c_top;
    logic [FW-1:0] raw_flags;

    operand_prep #(.W(W)) u_prep (
        .b_in (opb),
        .sub  (op_sub),
        .b_eff(b_eff),
        .cin  (cin)
    );

    ripple_adder #(.W(W)) u_add (
        .a         (opa),
        .b         (b_eff),
        .cin       (cin),
        .sum       (raw_sum),
        .c_into_msb(c_msb),
        .c_out     (c_top)
    );

    flag_gen #(.W(W), .FW(FW)) u_flags (
        .sum       (raw_sum),
        .c_into_msb(c_msb),
        .c_out     (c_top),
        .flags     (raw_flags)
    );

    // Capture the result and status on an accepted operation; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_out   <= '0;
            flags_out <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                sum_out   <= raw_sum;
                flags_out <= raw_flags;
            end
        end
    end

    // R2: add mode yields the truncated sum.
    a_r2_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_sub |=> sum_out == W'($past(opa) + $past(opb)));

    // R3: subtract mode yields the truncated difference.
    a_r3_sub_diff: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_sub |=> sum_out == W'($past(opa) - $past(opb)));

    // R4: in subtract mode, carry means no borrow.
    a_r4_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_sub |=> flags_out[FLAG_CARRY] == ($past(opa) >= $past(opb)));

    // R5: the zero flag agrees with the captured result.
    a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> flags_out[FLAG_ZERO] == (sum_out == '0));

    // R6: the negative flag mirrors the result sign.
    a_r6_sign: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> flags_out[FLAG_NEG] == sum_out[MSB]);

    // R7: add overflow means like-signed operands gave a result of the other sign.
    a_r7_add_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_sub |=> flags_out[FLAG_OVF] ==
            (($past(opa[MSB]) == $past(opb[MSB])) && (sum_out[MSB] != $past(opa[MSB]))));

    // R8: reserved status bits stay zero.
    a_r8_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        flags_out[FW-1:FLAG_USED] == '0);

    // R9: an accepted operation produces the pulse on the next cycle.
    a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    // R9: with no strobe, the outputs hold and no pulse is produced.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid && $stable(sum_out) && $stable(flags_out));
endmodule

// File: tb/addsub_flags_unit_test.sv
// Bench for addsub_flags_unit.
// Mixes directed corner cases with seeded random operations and compares the
// outputs against models computed in bench functions.
module addsub_flags_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic       op_sub = 1'b0;
    logic [7:0] opa = '0;
    logic [7:0] opb = '0;
    logic [7:0] sum_out;
    logic [7:0] flags_out;
    logic       res_valid;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    addsub_flags_unit uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_sub   (op_sub),
        .opa      (opa),
        .opb      (opb),
        .sum_out  (sum_out),
        .flags_out(flags_out),
        .res_valid(res_valid)
    );

    // Model of the 8-bit result.
    function automatic logic [7:0] exp_result(input logic [7:0] a, input logic [7:0] b,
                                              input logic sub);
        return sub ? 8'(a - b) : 8'(a + b);
    endfunction

    // Model of the status word from the requirements.
    function automatic logic [7:0] exp_flags(input logic [7:0] a, input logic [7:0] b,
                                             input logic sub);
        logic [8:0] wide;
        logic [7:0] r;
        logic c, v;
        wide = sub ? ({1'b0, a} + {1'b0, ~b} + 9'd1) : ({1'b0, a} + {1'b0, b});
        r = wide[7:0];
        c = sub ? (a >= b) : wide[8];
        v = sub ? ((a[7] != b[7]) && (r[7] != a[7])) : ((a[7] == b[7]) && (r[7] != a[7]));
        return {4'b0000, v, r[7], (r == 8'h00), c};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one operation, then check every output half a period after capture.
    task automatic do_op(input logic [7:0] a, input logic [7:0] b, input logic sub);
        logic [7:0] ef;
        @(negedge clk);
        opa = a; opb = b; op_sub = sub; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        ef = exp_flags(a, b, sub);
        check("R9 valid pulse", 32'(res_valid), 32'd1);
        check(sub ? "R3 difference" : "R2 sum", 32'(sum_out), 32'(exp_result(a, b, sub)));
        check("R4 carry", 32'(flags_out[0]), 32'(ef[0]));
        check("R5 zero", 32'(flags_out[1]), 32'(ef[1]));
        check("R6 negative", 32'(flags_out[2]), 32'(ef[2]));
        check("R7 overflow", 32'(flags_out[3]), 32'(ef[3]));
        check("R8 reserved", 32'(flags_out[7:4]), 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] hold_sum, hold_flags;
        void'($urandom(32'd20240611));

        // R1: reset clears the outputs.
        repeat (3) @(negedge clk);
        check("R1 result", 32'(sum_out), 32'd0);
        check("R1 flags", 32'(flags_out), 32'd0);
        check("R1 valid", 32'(res_valid), 32'd0);
        rst_n = 1'b1;

        // Directed corner cases.
        do_op(8'd115, 8'd91, 1'b0);   // R7: positive overflow to 11001110
        check("R7 example result", 32'(sum_out), 32'hCE);
        do_op(8'h80, 8'h80, 1'b0);    // R7: negative overflow, R4 carry, R5 zero
        do_op(8'd5, 8'hFB, 1'b0);     // R5: value plus its twos complement
        do_op(8'd17, 8'd10, 1'b1);    // R4: no borrow, R3 difference 7
        do_op(8'd10, 8'd17, 1'b1);    // R4: borrow, R6 negative result
        do_op(8'h42, 8'h42, 1'b1);    // R5: equal operands give zero, carry set
        do_op(8'h7F, 8'hFF, 1'b1);    // R7: 127 - (-1) overflows
        do_op(8'h80, 8'h01, 1'b1);    // R7: -128 - 1 overflows
        do_op(8'h00, 8'h00, 1'b1);    // R4: 0 - 0 gives carry 1
        do_op(8'hFF, 8'h01, 1'b0);    // R4: unsigned wrap gives carry 1

        // R9: with no strobe the outputs hold and no pulse is seen.
        hold_sum = sum_out;
        hold_flags = flags_out;
        @(negedge clk);
        opa = 8'h12; opb = 8'h34; op_sub = 1'b1;
        @(negedge clk);
        check("R9 no pulse", 32'(res_valid), 32'd0);
        check("R9 result held", 32'(sum_out), 32'(hold_sum));
        check("R9 flags held", 32'(flags_out), 32'(hold_flags));

        // Random operations.
        for (int i = 0; i < 400; i++) begin
            do_op(8'($urandom()), 8'($urandom()), 1'($urandom()));
        end

        // R1: a mid-run reset clears the outputs again.
        do_op(8'h33, 8'h44, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        check("R1 result after reset", 32'(sum_out), 32'd0);
        check("R1 flags after reset", 32'(flags_out), 32'd0);
        check("R1 valid after reset", 32'(res_valid), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule